// File: doc/BRIEF.md
# Integer ALU with Logical Shifter

This block is the combinational execute unit of a small RISC-style integer core. A separate decoder supplies a 4-bit operation code. The block returns one result word, plus a flag that is high when the result is all zeros. Two register operands enter on `opd_a_i` and `opd_b_i`. Shifts act on the second operand, and their distance comes from a separate immediate field, `shamt_i`. The first operand plays no part in a shift.

The block has no clock and no handshake. The result is valid in the same cycle as the inputs, so the core registers it where its pipeline needs. Sums and differences wrap around, and there is no carry or overflow output. There is no dedicated invert operation: software obtains one's complement by running NOR with a zero second operand. The two compare operations return 0 or 1, which suits compare-and-branch sequences. Branch-on-equal logic can use the zero flag after a subtraction.

The data width `DATA_W` is a parameter, 32 by default, and must be a power of two. The shift field is log2(`DATA_W`) bits wide.

Top module: `alu_core`

## Requirements
- R1: With `op_sel_i` = 0 (add), the result is (A + B) modulo 2^DATA_W.
- R2: With `op_sel_i` = 1 (subtract), the result is (A - B) modulo 2^DATA_W.
- R3: With `op_sel_i` = 2 the result is A AND B, and with `op_sel_i` = 3 it is A OR B, bit by bit.
- R4: With `op_sel_i` = 4 the result is NOT (A OR B). With B = 0 this yields the bitwise inverse of A.
- R5: With `op_sel_i` = 6 (unsigned compare), the result is 1 when A < B as unsigned numbers and 0 otherwise, with all upper bits zero.
- R6: With `op_sel_i` = 5 (signed compare), the result is 1 when A < B in two's complement and 0 otherwise. This holds even when A - B overflows.
- R7: With `op_sel_i` = 7 (shift left), the result is B moved toward the MSB by `shamt_i` places, with zeros in the vacated low bits.
- R8: With `op_sel_i` = 8 (shift right), the result is B moved toward the LSB by `shamt_i` places, with zeros in the vacated high bits. This equals B divided by 2^`shamt_i`, unsigned.
- R9: For both shifts, a shift amount of 0 returns B unchanged, and the value of A has no effect on the result.
- R10: `zero_o` is 1 exactly when every bit of `result_o` is 0.
- R11: Operation codes 9 to 15 produce an all-zero result, and so `zero_o` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opd_a_i | input | DATA_W | First operand (left side of add, subtract and compare) |
| opd_b_i | input | DATA_W | Second operand; also the value that shifts move |
| shamt_i | input | log2(DATA_W) | Immediate shift distance |
| op_sel_i | input | 4 | Operation code from the decoder |
| result_o | output | DATA_W | Result word |
| zero_o | output | 1 | High when the result is all zeros |

## Verification
The assertions are immediate checks inside the combinational logic, so they assume that every input bit holds a known 0 or 1. They also assume `DATA_W` is a power of two, so a shift amount can never reach the data width. The stimulus keeps to these assumptions: it always drives fully defined operands and codes. It sweeps every operand pair and every shift distance on an 8-bit instance, where the shift field is 3 bits. It also uses sign-boundary corner values and random words on the 32-bit default instance.

// File: rtl/alu_pkg.sv
`timescale 1ns/1ps
package alu_pkg;
  typedef enum logic [3:0] {
    ALU_ADD  = 4'd0,
    ALU_SUB  = 4'd1,
    ALU_AND  = 4'd2,
    ALU_OR   = 4'd3,
    ALU_NOR  = 4'd4,
    ALU_SLT  = 4'd5,
    ALU_SLTU = 4'd6,
    ALU_SLL  = 4'd7,
    ALU_SRL  = 4'd8
  } alu_op_e;
endpackage

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
// Shared adder: add or subtract, plus both less-than decisions taken from the difference.
module alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         lt_s_o,
  output logic         lt_u_o
);
  logic [W-1:0] b_eff;
  logic [W:0]   full;
  logic         carry;
  logic         ovf;

  assign b_eff  = sub_i ? ~b_i : b_i;
  assign full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};
  assign sum_o  = full[W-1:0];
  assign carry  = full[W];
  // Two's-complement overflow: both addends share a sign that the sum lost.
  assign ovf    = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
  assign lt_s_o = sum_o[W-1] ^ ovf;
  // While subtracting, a missing carry means a borrow occurred.
  assign lt_u_o = ~carry;

  always_comb begin
    if (sub_i) begin
      AST_SUB_REVERSE: assert (W'(sum_o + b_i) == a_i);          // R2
      AST_LTU_ORDER:   assert (lt_u_o == (a_i < b_i));           // R5
      AST_LTS_ORDER:   assert (lt_s_o == ($signed(a_i) < $signed(b_i))); // R6
    end else begin
      AST_ADD_REVERSE: assert (W'(sum_o - b_i) == a_i);          // R1
    end
  end
endmodule

// File: rtl/alu_shift.sv
`timescale 1ns/1ps
// Logarithmic logical shifter: one stage for each bit of the shift amount.
module alu_shift #(
  parameter int W   = 32,
  parameter int SHW = 5
) (
  input  logic [W-1:0]   val_i,
  input  logic [SHW-1:0] amt_i,
  input  logic           left_i,
  output logic [W-1:0]   val_o
);
  logic [W-1:0] stage [SHW+1];

  assign stage[0] = val_i;

  for (genvar k = 0; k < SHW; k++) begin : g_stage
    localparam int DIST = 1 << k;
    assign stage[k+1] = !amt_i[k] ? stage[k] :
                        (left_i ? (stage[k] << DIST) : (stage[k] >> DIST));
  end

  assign val_o = stage[SHW];

  localparam logic [W-1:0] ONE = 1;

  always_comb begin
    if (amt_i == '0) begin
      AST_SHIFT_IDENTITY: assert (val_o == val_i);                        // R9
    end
    if (left_i) begin
      AST_SLL_FILL: assert ((val_o & ((ONE << amt_i) - ONE)) == '0);      // R7
    end else begin
      AST_SRL_FILL: assert ((val_o & ~({W{1'b1}} >> amt_i)) == '0);       // R8
    end
  end
endmodule

// File: rtl/alu_logic.sv
`timescale 1ns/1ps
// Bitwise unit; inversion is reached only through NOR.
module alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] and_o,
  output logic [W-1:0] or_o,
  output logic [W-1:0] nor_o
);
  assign and_o = a_i & b_i;
  assign or_o  = a_i | b_i;
  assign nor_o = ~(a_i | b_i);

  always_comb begin
    AST_NOR_DISJOINT: assert ((nor_o & a_i) == '0 && (nor_o & b_i) == '0); // R4
    AST_AND_WITHIN_OR: assert ((and_o & ~or_o) == '0);                     // R3
  end
endmodule

// File: rtl/alu_core.sv
`timescale 1ns/1ps
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opd_a_i,
  input  logic [DATA_W-1:0] opd_b_i,
  input  logic [SH_W-1:0]   shamt_i,
  input  logic [3:0]        op_sel_i,
  output logic [DATA_W-1:0] result_o,
  output logic              zero_o
);
  logic [DATA_W-1:0] sum;
  logic              lt_s;
  logic              lt_u;
  logic [DATA_W-1:0] and_v;
  logic [DATA_W-1:0] or_v;
  logic [DATA_W-1:0] nor_v;
  logic [DATA_W-1:0] shifted;
  logic              do_sub;
  logic              go_left;

  // Every code but add runs the adder as a subtractor, including the compares.
  assign do_sub  = (op_sel_i != ALU_ADD);
  assign go_left = (op_sel_i == ALU_SLL);

  alu_addsub #(.W(DATA_W)) u_addsub (
    .a_i    (opd_a_i),
    .b_i    (opd_b_i),
    .sub_i  (do_sub),
    .sum_o  (sum),
    .lt_s_o (lt_s),
    .lt_u_o (lt_u)
  );

  alu_logic #(.W(DATA_W)) u_logic (
    .a_i   (opd_a_i),
    .b_i   (opd_b_i),
    .and_o (and_v),
    .or_o  (or_v),
    .nor_o (nor_v)
  );

  alu_shift #(.W(DATA_W), .SHW(SH_W)) u_shift (
    .val_i  (opd_b_i),
    .amt_i  (shamt_i),
    .left_i (go_left),
    .val_o  (shifted)
  );

  always_comb begin
    unique case (op_sel_i)
      ALU_ADD, ALU_SUB: result_o = sum;
      ALU_AND:          result_o = and_v;
      ALU_OR:           result_o = or_v;
      ALU_NOR:          result_o = nor_v;
      ALU_SLT:          result_o = {{(DATA_W-1){1'b0}}, lt_s};
      ALU_SLTU:         result_o = {{(DATA_W-1){1'b0}}, lt_u};
      ALU_SLL, ALU_SRL: result_o = shifted;
      default:          result_o = '0;
    endcase
  end

  assign zero_o = ~|result_o;

  always_comb begin
    AST_ZERO_FLAG: assert (zero_o == (result_o == '0));                          // R10
    if (op_sel_i == ALU_SLT || op_sel_i == ALU_SLTU) begin
      AST_COMPARE_RANGE: assert (result_o[DATA_W-1:1] == '0);                    // R5
    end
    if (op_sel_i > ALU_SRL) begin
      AST_UNUSED_CODE: assert (zero_o);                                          // R11
    end
    if (op_sel_i == ALU_NOR && opd_b_i == '0) begin
      AST_NOR_INVERT: assert (result_o == ~opd_a_i);                             // R4
    end
  end
endmodule

// File: tb/test_alu_core.sv
`timescale 1ns/1ps
module test_alu_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // 32-bit default instance
  logic [31:0] a32, b32, res32;
  logic [4:0]  sh32;
  logic [3:0]  op32;
  logic        z32;
  // 8-bit instance for exhaustive sweeps
  logic [7:0]  a8, b8, res8;
  logic [2:0]  sh8;
  logic [3:0]  op8;
  logic        z8;

  alu_core i_alu_core (
    .opd_a_i(a32), .opd_b_i(b32), .shamt_i(sh32), .op_sel_i(op32),
    .result_o(res32), .zero_o(z32)
  );

  alu_core #(.DATA_W(8)) i_alu_core_w8 (
    .opd_a_i(a8), .opd_b_i(b8), .shamt_i(sh8), .op_sel_i(op8),
    .result_o(res8), .zero_o(z8)
  );

  function automatic string req_of(logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2, 4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R6";
      4'd6: return "R5";
      4'd7: return "R7";
      4'd8: return "R8";
      default: return "R11";
    endcase
  endfunction

  function automatic logic [31:0] ref_alu(int w, logic [3:0] op,
                                          logic [31:0] a, logic [31:0] b, int sh);
    logic [31:0] m;
    logic signed [31:0] sa, sb;
    m  = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 32'd1);
    sa = a << (32 - w);
    sb = b << (32 - w);
    case (op)
      4'd0: return (a + b) & m;
      4'd1: return (a - b) & m;
      4'd2: return a & b;
      4'd3: return a | b;
      4'd4: return ~(a | b) & m;
      4'd5: return {31'd0, sa < sb};
      4'd6: return {31'd0, a < b};
      4'd7: return (b << sh) & m;
      4'd8: return b >> sh;
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic vec8(logic [3:0] op, logic [7:0] a, logic [7:0] b, logic [2:0] sh);
    logic [31:0] e;
    op8 = op; a8 = a; b8 = b; sh8 = sh;
    #0.5;
    e = ref_alu(8, op, {24'd0, a}, {24'd0, b}, int'(sh));
    chk(req_of(op), {24'd0, res8}, e);
    chk("R10", {31'd0, z8}, {31'd0, e == 32'd0});
    #0.5;
  endtask

  task automatic vec32(logic [3:0] op, logic [31:0] a, logic [31:0] b, logic [4:0] sh);
    logic [31:0] e;
    op32 = op; a32 = a; b32 = b; sh32 = sh;
    #0.5;
    e = ref_alu(32, op, a, b, int'(sh));
    chk(req_of(op), res32, e);
    chk("R10", {31'd0, z32}, {31'd0, e == 32'd0});
    #0.5;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: got %0d cycles expected under 190000", cycles);
      finish_run();
    end
  end

  logic [31:0] corners [8];

  initial begin
    corners[0] = 32'h0000_0000; corners[1] = 32'h0000_0001;
    corners[2] = 32'h7FFF_FFFF; corners[3] = 32'h8000_0000;
    corners[4] = 32'hFFFF_FFFF; corners[5] = 32'h5555_5555;
    corners[6] = 32'hAAAA_AAAA; corners[7] = 32'h1234_5678;
    a32 = '0; b32 = '0; sh32 = '0; op32 = '0;
    a8 = '0; b8 = '0; sh8 = '0; op8 = '0;
    #0.1;
    // Reset-state check: all-zero inputs give a zero result and a raised flag (R10)
    #3.5;
    chk("R10", {res32, 31'd0, z32}, {32'd0, 31'd0, 1'b1});
    chk("R10", {24'd0, res8, 31'd0, z8}, {32'd0, 31'd0, 1'b1});
    #6.5;
    rst_n = 1'b1;
    #0.5;
    // Exhaustive 8-bit sweep of arithmetic, logic and compares (R1..R6); shamt varies and is ignored
    for (int op = 0; op <= 6; op++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++)
          vec8(4'(op), 8'(a), 8'(b), 3'(a ^ b));
    // Exhaustive 8-bit shifts (R7, R8), with A varied to show it is ignored (R9)
    for (int op = 7; op <= 8; op++)
      for (int b = 0; b < 256; b++)
        for (int sh = 0; sh < 8; sh++)
          vec8(4'(op), 8'(b * 37 + sh), 8'(b), 3'(sh));
    // Unused codes give zero (R11)
    for (int op = 9; op < 16; op++)
      for (int b = 0; b < 256; b += 17)
        vec8(4'(op), 8'(~b), 8'(b), 3'(b));
    // 32-bit corner pairs over every code, including signed overflow compares (R6)
    for (int op = 0; op < 16; op++)
      for (int i = 0; i < 8; i++)
        for (int j = 0; j < 8; j++)
          vec32(4'(op), corners[i], corners[j], 5'(i * 4 + j));
    // Inversion through NOR with zero (R4)
    for (int i = 0; i < 8; i++)
      vec32(4'd4, corners[i], 32'd0, 5'd0);
    // Full shift range on 32 bits, zero amount returns B (R9)
    for (int sh = 0; sh < 32; sh++) begin
      vec32(4'd7, 32'hDEAD_BEEF, 32'h8765_4321, 5'(sh));
      vec32(4'd8, 32'h0BAD_F00D, 32'hF000_000F, 5'(sh));
    end
    // Random 32-bit operands
    for (int k = 0; k < 3000; k++)
      vec32(4'($urandom_range(0, 8)), $urandom, $urandom, 5'($urandom));
    finish_run();
  end
endmodule